// File: doc/BRIEF.md
# Indexed-Enable Interrupt Controller Core

This block collects level-sensitive interrupt requests from a parameterised number of sources and delivers them to a parameterised number of CPUs, one interrupt line per CPU. Software talks to it through a flat 32-bit register port. The port carries a CPU number with every access, so the per-CPU registers are banked behind one address each. Enables and masks are never changed by read-modify-write. Software writes a source number to a dedicated set or clear address, and only that one source's bit changes.

A source reaches a CPU when five conditions hold: the controller is switched on, the source's input is high, the source is globally enabled, the source is unmasked for that CPU, and the source's routing word selects that CPU. A CPU's current task priority must also be zero. Each CPU can read an acknowledge register. It returns the lowest-numbered source that reaches that CPU, or 0x3FF when no source does. Each CPU can also read a cause register, which is a bit vector of the sources that reach it.

Top module: `idx_irq_ctrl`

## Requirements
- R1: After reset the controller is off and every `irq_o` bit is 0. All sources are disabled, masked for every CPU and unrouted, and every task priority is 0. A read of offset 0x000 returns the source count N_SRC in bits [11:2] and 0 in bit 0.
- R2: A write to offset 0x000 sets the on bit from `reg_wdata[0]`, and the on bit reads back in bit 0. While the controller is off, no `irq_o` bit rises and every acknowledge read returns 0x3FF.
- R3: A write of a source number in `reg_wdata[9:0]` to offset 0x030 enables that source. The same write to offset 0x034 disables it. A number of N_SRC or more is ignored, with no truncation of the index.
- R4: A write of a source number to offset 0x048 masks that source, and a write to offset 0x04C unmasks it. Either write affects only the CPU given on `reg_cpu`, and a number of N_SRC or more is ignored.
- R5: The routing word of source s lies at offset 0x100 + 4*s. Bit c of that word routes the source to CPU c, and the bits read back. All other bits are dropped on a write and read as 0. Addresses past the last source are neither stored nor read back.
- R6: `irq_o[c]` is the OR of the sources that reach CPU c. The output is registered, so it changes one clock after its inputs change.
- R7: A read of offset 0x044 returns, in bits [9:0], the lowest-numbered source that reaches CPU `reg_cpu`, with the upper bits 0. It returns 0x3FF when no source reaches that CPU. The read has no side effect.
- R8: Offset 0x040 holds a TPR_W-bit task priority for each CPU, and the value reads back. While that value is nonzero, no source reaches that CPU.
- R9: A read of offset 0x010 returns, for CPU `reg_cpu`, a bit vector of the sources 0 to 31 that reach that CPU. Bit s stands for source s.
- R10: Read data appears on `reg_rdata` in the clock after `reg_rd` and reflects the state before that edge. `reg_rdata` is 0 after any clock without a read, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_cpu | input | CPU_W | CPU issuing the access, selects banked registers |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one clock after `reg_rd` |
| src_i | input | N_SRC | Level-sensitive source requests |
| irq_o | output | N_CPU | Interrupt line for each CPU |

## Verification
The hardest situation to reach from the ports is an index write whose number lies just above the implemented range, for example source 21 with 16 sources. If the controller truncated the index, it would alias a live source. The stimulus therefore first builds a state where the aliased source is visibly enabled, unmasked and winning arbitration, and only then issues the out-of-range set and clear writes. The acknowledge read shows whether the live source was hit. Arbitration between CPUs is reached by routing one source to both CPUs and masking it for only one of them, which makes the two acknowledge values differ. A long random phase then mixes every register with changing source levels against the reference model.

// File: rtl/idx_irq_pkg.sv
`timescale 1ns/1ps
package idx_irq_pkg;
   localparam int               ICC_ID_W  = 10;
   localparam logic [9:0]       ICC_NONE  = 10'h3FF;
   localparam logic [11:0]      OFS_CTRL  = 12'h000;
   localparam logic [11:0]      OFS_CAUSE = 12'h010;
   localparam logic [11:0]      OFS_EN_S  = 12'h030;
   localparam logic [11:0]      OFS_EN_C  = 12'h034;
   localparam logic [11:0]      OFS_TPR   = 12'h040;
   localparam logic [11:0]      OFS_ACK   = 12'h044;
   localparam logic [11:0]      OFS_MSK_S = 12'h048;
   localparam logic [11:0]      OFS_MSK_C = 12'h04C;
   localparam logic [9:0]       ROUTE_W0  = 10'h040;
endpackage

// File: rtl/idx_irq_src_table.sv
`timescale 1ns/1ps
module idx_irq_src_table
   import idx_irq_pkg::*;
#(
   parameter int N_SRC = 16,
   parameter int N_CPU = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en_set_i,
   input  logic                           en_clr_i,
   input  logic [ICC_ID_W-1:0]            idx_i,
   input  logic                           route_wr_i,
   input  logic [ICC_ID_W-1:0]            route_idx_i,
   input  logic [N_CPU-1:0]               route_data_i,
   output logic [N_SRC-1:0]               en_o,
   output logic [N_SRC-1:0][N_CPU-1:0]    route_o
);
   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      localparam logic [ICC_ID_W-1:0] MY_ID = ICC_ID_W'(s);

      always_ff @(posedge clk) begin
         if (!rst_n)
            en_o[s] <= 1'b0;
         else if (en_set_i && idx_i == MY_ID)
            en_o[s] <= 1'b1;
         else if (en_clr_i && idx_i == MY_ID)
            en_o[s] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            route_o[s] <= '0;
         else if (route_wr_i && route_idx_i == MY_ID)
            route_o[s] <= route_data_i;
      end
   end
endmodule

// File: rtl/idx_irq_cpu_bank.sv
`timescale 1ns/1ps
module idx_irq_cpu_bank
   import idx_irq_pkg::*;
#(
   parameter int N_SRC   = 16,
   parameter int TPR_W   = 4,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  msk_set_i,
   input  logic                  msk_clr_i,
   input  logic [ICC_ID_W-1:0]   idx_i,
   input  logic                  tpr_wr_i,
   input  logic [TPR_W-1:0]      tpr_data_i,
   input  logic                  on_i,
   input  logic [N_SRC-1:0]      src_i,
   input  logic [N_SRC-1:0]      en_i,
   input  logic [N_SRC-1:0]      route_i,
   output logic [N_SRC-1:0]      elig_o,
   output logic [ICC_ID_W-1:0]   ack_o,
   output logic [TPR_W-1:0]      tpr_o,
   output logic                  irq_o
);
   logic [N_SRC-1:0] mask_q;
   logic             open_w;

   for (genvar s = 0; s < N_SRC; s++) begin : g_mask
      localparam logic [ICC_ID_W-1:0] MY_ID = ICC_ID_W'(s);
      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_q[s] <= 1'b1;
         else if (msk_set_i && idx_i == MY_ID)
            mask_q[s] <= 1'b1;
         else if (msk_clr_i && idx_i == MY_ID)
            mask_q[s] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         tpr_o <= '0;
      else if (tpr_wr_i)
         tpr_o <= tpr_data_i;
   end

   assign open_w = on_i && (tpr_o == '0);
   assign elig_o = src_i & en_i & ~mask_q & route_i & {N_SRC{open_w}};

   always_comb begin
      ack_o = ICC_NONE;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (elig_o[i])
            ack_o = ICC_ID_W'(i);
      end
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq_o <= 1'b0;
         else
            irq_o <= |elig_o;
      end
   end else begin : g_irq_comb
      assign irq_o = |elig_o;
   end
endmodule

// File: rtl/idx_irq_ctrl.sv
`timescale 1ns/1ps
module idx_irq_ctrl
   import idx_irq_pkg::*;
#(
   parameter int N_SRC   = 16,
   parameter int N_CPU   = 2,
   parameter int TPR_W   = 4,
   parameter bit IRQ_REG = 1'b1,
   localparam int CPU_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [CPU_W-1:0]  reg_cpu,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [N_SRC-1:0]  src_i,
   output logic [N_CPU-1:0]  irq_o
);
   localparam int CAUSE_N = (N_SRC < 32) ? N_SRC : 32;

   if (N_SRC < 1 || N_SRC > 960) begin : g_bad_nsrc
      $fatal(1, "N_SRC must lie in 1..960");
   end
   if (N_CPU < 1 || N_CPU > 8) begin : g_bad_ncpu
      $fatal(1, "N_CPU must lie in 1..8");
   end
   if (TPR_W < 1 || TPR_W > 32) begin : g_bad_tpr
      $fatal(1, "TPR_W must lie in 1..32");
   end

   logic [ICC_ID_W-1:0]                 wr_idx;
   logic [9:0]                          word;
   logic [ICC_ID_W-1:0]                 route_idx;
   logic                                route_hit;
   logic                                on_q;
   logic [N_SRC-1:0]                    src_en;
   logic [N_SRC-1:0][N_CPU-1:0]         route;
   logic [N_CPU-1:0][N_SRC-1:0]         elig;
   logic [N_CPU-1:0][ICC_ID_W-1:0]      ack_id;
   logic [N_CPU-1:0][TPR_W-1:0]         tpr;
   logic [31:0]                         rd_mux;

   assign wr_idx    = reg_wdata[ICC_ID_W-1:0];
   assign word      = reg_addr[11:2];
   assign route_idx = word - ROUTE_W0;
   assign route_hit = (word >= ROUTE_W0) && (route_idx < ICC_ID_W'(N_SRC));

   always_ff @(posedge clk) begin
      if (!rst_n)
         on_q <= 1'b0;
      else if (reg_wr && reg_addr == OFS_CTRL)
         on_q <= reg_wdata[0];
   end

   idx_irq_src_table #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_set_i    (reg_wr && reg_addr == OFS_EN_S),
      .en_clr_i    (reg_wr && reg_addr == OFS_EN_C),
      .idx_i       (wr_idx),
      .route_wr_i  (reg_wr && route_hit),
      .route_idx_i (route_idx),
      .route_data_i(reg_wdata[N_CPU-1:0]),
      .en_o        (src_en),
      .route_o     (route)
   );

   for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      logic [N_SRC-1:0] col;
      logic             mine;

      for (genvar s = 0; s < N_SRC; s++) begin : g_col
         assign col[s] = route[s][c];
      end
      assign mine = (reg_cpu == CPU_W'(c));

      idx_irq_cpu_bank #(.N_SRC(N_SRC), .TPR_W(TPR_W), .IRQ_REG(IRQ_REG)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .msk_set_i (reg_wr && mine && reg_addr == OFS_MSK_S),
         .msk_clr_i (reg_wr && mine && reg_addr == OFS_MSK_C),
         .idx_i     (wr_idx),
         .tpr_wr_i  (reg_wr && mine && reg_addr == OFS_TPR),
         .tpr_data_i(reg_wdata[TPR_W-1:0]),
         .on_i      (on_q),
         .src_i     (src_i),
         .en_i      (src_en),
         .route_i   (col),
         .elig_o    (elig[c]),
         .ack_o     (ack_id[c]),
         .tpr_o     (tpr[c]),
         .irq_o     (irq_o[c])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (route_hit) begin
         for (int s = 0; s < N_SRC; s++) begin
            if (route_idx == ICC_ID_W'(s))
               rd_mux[N_CPU-1:0] = route[s];
         end
      end else begin
         case (reg_addr)
            OFS_CTRL: rd_mux = {20'd0, 10'(N_SRC), 1'b0, on_q};
            OFS_CAUSE: begin
               for (int c = 0; c < N_CPU; c++) begin
                  if (reg_cpu == CPU_W'(c))
                     rd_mux[CAUSE_N-1:0] = elig[c][CAUSE_N-1:0];
               end
            end
            OFS_ACK: begin
               for (int c = 0; c < N_CPU; c++) begin
                  if (reg_cpu == CPU_W'(c))
                     rd_mux[ICC_ID_W-1:0] = ack_id[c];
               end
            end
            OFS_TPR: begin
               for (int c = 0; c < N_CPU; c++) begin
                  if (reg_cpu == CPU_W'(c))
                     rd_mux[TPR_W-1:0] = tpr[c];
               end
            end
            default: rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         reg_rdata <= '0;
      else
         reg_rdata <= reg_rd ? rd_mux : 32'd0;
   end
endmodule

// File: rtl/idx_irq_ctrl_chk.sv
`timescale 1ns/1ps
module idx_irq_ctrl_chk
   import idx_irq_pkg::*;
#(
   parameter int N_SRC = 16,
   parameter int N_CPU = 2,
   parameter int TPR_W = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            reg_wr,
   input logic                            reg_rd,
   input logic [11:0]                     reg_addr,
   input logic [31:0]                     reg_wdata,
   input logic [31:0]                     reg_rdata,
   input logic [N_CPU-1:0]                irq_o,
   input logic                            on_q,
   input logic [N_SRC-1:0]                src_en,
   input logic [N_CPU-1:0][N_SRC-1:0]     elig,
   input logic [N_CPU-1:0][ICC_ID_W-1:0]  ack_id,
   input logic [N_CPU-1:0][TPR_W-1:0]     tpr
);
   assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!on_q && !$past(on_q)) |-> (irq_o == '0));

   assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_rd) |-> (reg_rdata == 32'd0));

   assert_oor_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == OFS_EN_S || reg_addr == OFS_EN_C)
       && reg_wdata[ICC_ID_W-1:0] >= ICC_ID_W'(N_SRC)) |=> $stable(src_en));

   for (genvar c = 0; c < N_CPU; c++) begin : g_cpu_chk
      assert_ack_none_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !on_q |-> (ack_id[c] == ICC_NONE));

      assert_ack_found_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (elig[c] != '0) |-> (ack_id[c] < ICC_ID_W'(N_SRC)));

      assert_ack_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_id[c] != ICC_NONE) |->
            ((((elig[c] >> ack_id[c]) & N_SRC'(1)) != '0)
             && ((elig[c] << (N_SRC - int'(ack_id[c]))) == '0)));

      assert_tpr_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (tpr[c] != '0) |-> (elig[c] == '0));
   end
endmodule

bind idx_irq_ctrl idx_irq_ctrl_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU), .TPR_W(TPR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .irq_o    (irq_o),
   .on_q     (on_q),
   .src_en   (src_en),
   .elig     (elig),
   .ack_id   (ack_id),
   .tpr      (tpr)
);

// File: tb/test_idx_irq_ctrl.sv
`timescale 1ns/1ps
module test_idx_irq_ctrl;
   localparam int NS = 16;
   localparam int NC = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_wr, reg_rd;
   logic [0:0]    reg_cpu;
   logic [11:0]   reg_addr;
   logic [31:0]   reg_wdata;
   logic [31:0]   reg_rdata;
   logic [NS-1:0] src;
   logic [NC-1:0] irq_o;

   always #2.5 clk = ~clk;

   idx_irq_ctrl #(.N_SRC(NS), .N_CPU(NC)) i_idx_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_cpu(reg_cpu), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .src_i(src), .irq_o(irq_o)
   );

   // reference model
   bit          m_on;
   bit          m_en   [NS];
   bit          m_mask [NC][NS];
   bit [NC-1:0] m_route[NS];
   int          m_tpr  [NC];
   int          checks = 0;
   int          fails  = 0;
   bit          done   = 1'b0;

   function automatic bit reaches(int c, int s);
      return src[s] && m_en[s] && !m_mask[c][s] && m_route[s][c] && m_on && m_tpr[c] == 0;
   endfunction

   function automatic logic [31:0] ack_of(int c);
      for (int s = 0; s < NS; s++) if (reaches(c, s)) return s;
      return 32'h3FF;
   endfunction

   function automatic logic [31:0] model_read(logic [11:0] a, int c);
      int w = int'(a >> 2);
      logic [31:0] v = '0;
      if (w >= 'h40 && w - 'h40 < NS) return 32'(m_route[w - 'h40]);
      case (a)
         12'h000: v = (NS << 2) | 32'(m_on);
         12'h010: for (int s = 0; s < NS; s++) v[s] = reaches(c, s);
         12'h040: v = m_tpr[c] & 32'hF;
         12'h044: v = ack_of(c);
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(bit wr, bit rd, logic [11:0] a, logic [31:0] d, int c, string tag);
      logic [NC-1:0] e_irq;
      logic [31:0]   e_rd;
      int            idx = int'(d[9:0]);
      int            w   = int'(a >> 2);
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; reg_cpu = 1'(c);
      for (int cc = 0; cc < NC; cc++) begin
         e_irq[cc] = 1'b0;
         for (int s = 0; s < NS; s++) if (reaches(cc, s)) e_irq[cc] = 1'b1;
      end
      e_rd = rd ? model_read(a, c) : 32'd0;
      if (wr) begin
         if (a == 12'h000) m_on = d[0];
         else if (a == 12'h030 && idx < NS) m_en[idx] = 1'b1;
         else if (a == 12'h034 && idx < NS) m_en[idx] = 1'b0;
         else if (a == 12'h048 && idx < NS) m_mask[c][idx] = 1'b1;
         else if (a == 12'h04C && idx < NS) m_mask[c][idx] = 1'b0;
         else if (a == 12'h040) m_tpr[c] = int'(d[3:0]);
         else if (w >= 'h40 && w - 'h40 < NS) m_route[w - 'h40] = d[NC-1:0];
      end
      @(posedge clk);
      @(negedge clk);
      check("R6 irq_o", 32'(irq_o), 32'(e_irq));
      check(tag, reg_rdata, e_rd);
      reg_wr = 1'b0; reg_rd = 1'b0;
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d, int c, string tag);
      step(1'b1, 1'b0, a, d, c, tag);
   endtask

   task automatic rd_expect(logic [11:0] a, int c, logic [31:0] exp, string tag);
      step(1'b0, 1'b1, a, 32'd0, c, tag);
      check(tag, reg_rdata, exp);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R6 actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_cpu = 0; reg_addr = 0; reg_wdata = 0;
      src = '1;
      m_on = 0;
      for (int s = 0; s < NS; s++) begin
         m_en[s] = 0; m_route[s] = '0;
         for (int c = 0; c < NC; c++) m_mask[c][s] = 1'b1;
      end
      for (int c = 0; c < NC; c++) m_tpr[c] = 0;
      repeat (3) @(negedge clk);
      check("R1 irq in reset", 32'(irq_o), 32'd0);
      rst_n = 1'b1;

      // R1 reset state
      rd_expect(12'h000, 0, 32'h40, "R1 ctrl reset");
      rd_expect(12'h044, 0, 32'h3FF, "R7 ack none after reset");
      rd_expect(12'h10C, 0, 32'h0, "R1 route reset");

      // R2 switch on
      wr(12'h000, 32'h1, 0, "R2 on");
      rd_expect(12'h000, 0, 32'h41, "R2 ctrl on");

      // R3/R5 enable and route source 5 to CPU0, still masked (R4)
      wr(12'h030, 32'd5, 0, "R3 enable 5");
      wr(12'h114, 32'h1, 0, "R5 route 5");
      rd_expect(12'h044, 0, 32'h3FF, "R4 masked source hidden");
      wr(12'h04C, 32'd5, 0, "R4 unmask 5 cpu0");
      rd_expect(12'h044, 0, 32'd5, "R7 ack cpu0 is 5");
      check("R6 irq after unmask", 32'(irq_o), 32'h1);
      rd_expect(12'h044, 1, 32'h3FF, "R4 cpu1 unaffected");

      // source 2 to both, unmasked on CPU1 only
      wr(12'h030, 32'd2, 0, "R3 enable 2");
      wr(12'h108, 32'h3, 0, "R5 route 2 both");
      wr(12'h04C, 32'd2, 1, "R4 unmask 2 cpu1");
      rd_expect(12'h044, 1, 32'd2, "R4 ack cpu1 is 2");
      rd_expect(12'h044, 0, 32'd5, "R4 ack cpu0 still 5");
      wr(12'h04C, 32'd2, 0, "R4 unmask 2 cpu0");
      rd_expect(12'h044, 0, 32'd2, "R7 lowest wins");
      rd_expect(12'h044, 0, 32'd2, "R7 ack read no side effect");
      rd_expect(12'h010, 0, 32'h24, "R9 cause cpu0");
      rd_expect(12'h010, 1, 32'h04, "R9 cause cpu1");

      // R3 out-of-range index must not alias source 5 or 2
      wr(12'h034, 32'd21, 0, "R3 oor clear");
      wr(12'h034, 32'd18, 0, "R3 oor clear");
      rd_expect(12'h044, 0, 32'd2, "R3 oor clear ignored");
      wr(12'h034, 32'd2, 0, "R3 clear 2");
      rd_expect(12'h044, 0, 32'd5, "R3 clear 2 took effect");
      wr(12'h030, 32'h3FF, 0, "R3 oor set");
      rd_expect(12'h044, 1, 32'h3FF, "R3 oor set ignored");
      wr(12'h048, 32'd21, 0, "R4 oor mask");
      rd_expect(12'h044, 0, 32'd5, "R4 oor mask ignored");
      wr(12'h048, 32'd5, 0, "R4 mask 5 cpu0");
      rd_expect(12'h044, 0, 32'h3FF, "R4 mask took effect");
      wr(12'h04C, 32'd5, 0, "R4 unmask 5 cpu0");

      // R5 routing word fields
      wr(12'h11C, 32'h301, 0, "R5 route 7 with extra bits");
      rd_expect(12'h11C, 0, 32'h1, "R5 extra bits dropped");
      wr(12'h140, 32'h3, 0, "R5 route past end");
      rd_expect(12'h140, 0, 32'h0, "R5 past end reads 0");

      // R8 task priority
      wr(12'h030, 32'd2, 0, "R3 re-enable 2");
      rd_expect(12'h044, 1, 32'd2, "R8 cpu1 open");
      wr(12'h040, 32'd3, 1, "R8 tpr cpu1");
      rd_expect(12'h040, 1, 32'd3, "R8 tpr readback");
      rd_expect(12'h044, 1, 32'h3FF, "R8 tpr blocks cpu1");
      check("R8 irq1 blocked", 32'(irq_o[1]), 32'd0);
      rd_expect(12'h044, 0, 32'd2, "R8 cpu0 unaffected");
      wr(12'h040, 32'd0, 1, "R8 tpr zero");
      rd_expect(12'h044, 1, 32'd2, "R8 tpr zero reopens");

      // R2 off
      wr(12'h000, 32'h0, 0, "R2 off");
      rd_expect(12'h044, 1, 32'h3FF, "R2 off ack none");
      check("R2 off irq", 32'(irq_o), 32'd0);
      wr(12'h000, 32'h1, 0, "R2 on again");

      // R6 level sensitivity
      src = '0;
      step(1'b0, 1'b0, 12'h000, 32'd0, 0, "R10 idle rdata");
      step(1'b0, 1'b0, 12'h000, 32'd0, 0, "R10 idle rdata");
      check("R6 level drop", 32'(irq_o), 32'd0);
      src = 16'h0020;
      step(1'b0, 1'b0, 12'h000, 32'd0, 0, "R10 idle rdata");
      step(1'b0, 1'b1, 12'h3F0, 32'd0, 0, "R10 unmapped");
      check("R6 level rise", 32'(irq_o), 32'h1);

      // random mix against the model
      for (int n = 0; n < 600; n++) begin
         int op  = int'($urandom_range(0, 11));
         int c   = int'($urandom_range(0, NC - 1));
         int idx = int'($urandom_range(0, 19));
         src = NS'($urandom);
         case (op)
            0: wr(12'h000, ($urandom_range(0, 9) < 8) ? 32'h1 : 32'h0, c, "R2 rnd");
            1: wr(12'h030, 32'(idx), c, "R3 rnd");
            2: wr(12'h034, 32'(idx), c, "R3 rnd");
            3: wr(12'h048, 32'(idx), c, "R4 rnd");
            4: wr(12'h04C, 32'(idx), c, "R4 rnd");
            5: wr(12'h040, ($urandom_range(0, 9) < 7) ? 32'd0 : 32'($urandom_range(1, 15)), c, "R8 rnd");
            6: wr(12'(32'h100 + 4 * idx), $urandom, c, "R5 rnd");
            7: step(1'b0, 1'b1, 12'h044, 32'd0, c, "R7 rnd ack");
            8: step(1'b0, 1'b1, 12'h010, 32'd0, c, "R9 rnd cause");
            9: step(1'b0, 1'b1, 12'(32'h100 + 4 * idx), 32'd0, c, "R5 rnd route");
            10: step(1'b0, 1'b1, 12'h040, 32'd0, c, "R8 rnd tpr");
            default: step(1'b0, 1'b0, 12'h000, 32'd0, c, "R10 rnd idle");
         endcase
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule